// File: doc/BRIEF.md
# Fetch Address Predictor and Selector

This block sits at the front of a five-stage in-order pipeline and decides which address the fetch stage reads each cycle. It keeps one register, the predicted PC, which it fills with a static guess made from the instruction just fetched. Instructions that do not change control flow are guessed to fall through to the incremented PC. Calls and unconditional jumps are guessed to go to their immediate target. Conditional jumps are always guessed taken. Returns get no real guess, so the fall-through address is used as a placeholder.

Two later stages can override the guess. A conditional jump that reaches the memory stage with a false condition was guessed wrong. Its fall-through address travels in that stage's A-operand value, and that value is fetched at once. A return that reaches write-back brings its return address as the value read from memory, and that value is fetched instead. The surrounding control logic stalls fetch while a return is in flight. The stall input is the block's only back-pressure: while it is high, the predicted-PC register keeps its contents. The two outputs are still recomputed from the current inputs. All other pins are plain level signals with no handshake.

Top module: `npc_unit`

## Requirements
- R1: For a fetched class that is not 4'h7, 4'h8, 4'h9 or 4'hA, `pred_pc` equals `f_inc_pc`.
- R2: For a fetched unconditional jump (class 4'h8) or call (class 4'h9), `pred_pc` equals `f_imm`.
- R3: For a fetched conditional jump (class 4'h7), `pred_pc` equals `f_imm`, because it is always guessed taken.
- R4: For a fetched return (class 4'hA), no target is guessed, and `pred_pc` equals `f_inc_pc`.
- R5: When `m_cls` is 4'h7 and `m_taken` is 0, `fetch_pc` equals `m_alt_pc`. A memory-stage conditional jump with `m_taken` at 1, or any other memory-stage class, causes no redirect.
- R6: When `w_cls` is 4'hA and R5 does not apply, `fetch_pc` equals `w_load`.
- R7: When the conditions of R5 and R6 hold in the same cycle, `fetch_pc` equals `m_alt_pc`.
- R8: When neither redirect applies, `fetch_pc` equals the predicted-PC register. On each rising clock edge with `stall_f` low and reset released, that register loads the `pred_pc` of that cycle.
- R9: On a rising edge with `stall_f` high, the predicted-PC register keeps its value.
- R10: While `rst_n` is low, the predicted-PC register is zero. With no redirect, `fetch_pc` then reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_f | input | 1 | Holds the predicted-PC register |
| f_cls | input | 4 | Class code of the instruction being fetched |
| f_inc_pc | input | ADDR_W | Address after the fetched instruction |
| f_imm | input | ADDR_W | Immediate destination of the fetched instruction |
| m_cls | input | 4 | Class code in the memory stage |
| m_taken | input | 1 | Condition outcome in the memory stage |
| m_alt_pc | input | ADDR_W | Fall-through address carried in the memory stage |
| w_cls | input | 4 | Class code in the write-back stage |
| w_load | input | ADDR_W | Value read from memory, in the write-back stage |
| fetch_pc | output | ADDR_W | Address to fetch this cycle |
| pred_pc | output | ADDR_W | Guessed address for the next fetch |

## Verification
The bench goes after cycles in which both redirect sources are active. A design with the priority reversed would fetch the return address down a path that should have been cancelled. Stalled cycles get their own checks. A register that loads while stalled would skip an instruction, and one that holds when not stalled would fetch the same address twice. The memory-stage jump with a true condition, and the false flag paired with a class other than conditional jump, are also aimed at. A design that keys only on the flag would redirect on these. Returns are checked to guess the fall-through address and not the immediate field.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int CLS_W = 4;
  typedef logic [CLS_W-1:0] cls_t;

  localparam cls_t CLS_JCC  = 4'h7;
  localparam cls_t CLS_JMP  = 4'h8;
  localparam cls_t CLS_CALL = 4'h9;
  localparam cls_t CLS_RET  = 4'hA;

  typedef enum logic [1:0] {
    SRC_PRED   = 2'd0,
    SRC_MISP   = 2'd1,
    SRC_RETURN = 2'd2
  } fetch_src_e;

  function automatic logic takes_imm(input cls_t c);
    return (c == CLS_JCC) || (c == CLS_JMP) || (c == CLS_CALL);
  endfunction
endpackage

// File: rtl/npc_static_pred.sv
module npc_static_pred
  import npc_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  cls_t              cls,
  input  logic [ADDR_W-1:0] inc_pc,
  input  logic [ADDR_W-1:0] imm,
  output logic [ADDR_W-1:0] guess
);
  always_comb begin
    unique case (cls)
      CLS_JCC, CLS_JMP, CLS_CALL: guess = imm;
      default:                    guess = inc_pc;
    endcase
  end
endmodule

// File: rtl/npc_redirect.sv
module npc_redirect
  import npc_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  cls_t              m_cls,
  input  logic              m_taken,
  input  logic [ADDR_W-1:0] m_alt_pc,
  input  cls_t              w_cls,
  input  logic [ADDR_W-1:0] w_load,
  input  logic [ADDR_W-1:0] pred_q,
  output logic [ADDR_W-1:0] fetch_pc
);
  fetch_src_e src;

  always_comb begin
    if (m_cls == CLS_JCC && !m_taken) src = SRC_MISP;
    else if (w_cls == CLS_RET)        src = SRC_RETURN;
    else                              src = SRC_PRED;
  end

  always_comb begin
    unique case (src)
      SRC_MISP:   fetch_pc = m_alt_pc;
      SRC_RETURN: fetch_pc = w_load;
      default:    fetch_pc = pred_q;
    endcase
  end
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (!hold) q <= d;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_f,
  input  logic [3:0]        f_cls,
  input  logic [ADDR_W-1:0] f_inc_pc,
  input  logic [ADDR_W-1:0] f_imm,
  input  logic [3:0]        m_cls,
  input  logic              m_taken,
  input  logic [ADDR_W-1:0] m_alt_pc,
  input  logic [3:0]        w_cls,
  input  logic [ADDR_W-1:0] w_load,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic [ADDR_W-1:0] pred_pc
);
  logic [ADDR_W-1:0] pred_q;

  npc_static_pred #(.ADDR_W(ADDR_W)) u_pred (
    .cls    (f_cls),
    .inc_pc (f_inc_pc),
    .imm    (f_imm),
    .guess  (pred_pc)
  );

  npc_pc_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (stall_f),
    .d     (pred_pc),
    .q     (pred_q)
  );

  npc_redirect #(.ADDR_W(ADDR_W)) u_sel (
    .m_cls    (m_cls),
    .m_taken  (m_taken),
    .m_alt_pc (m_alt_pc),
    .w_cls    (w_cls),
    .w_load   (w_load),
    .pred_q   (pred_q),
    .fetch_pc (fetch_pc)
  );
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall_f,
  input logic [3:0]        f_cls,
  input logic [ADDR_W-1:0] f_inc_pc,
  input logic [ADDR_W-1:0] f_imm,
  input logic [3:0]        m_cls,
  input logic              m_taken,
  input logic [ADDR_W-1:0] m_alt_pc,
  input logic [3:0]        w_cls,
  input logic [ADDR_W-1:0] w_load,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic [ADDR_W-1:0] pred_pc,
  input logic [ADDR_W-1:0] pred_q
);
  logic misp, retw;
  assign misp = (m_cls == CLS_JCC) && !m_taken;
  assign retw = (w_cls == CLS_RET);

  a_r1_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (!takes_imm(f_cls) && f_cls != CLS_RET) |-> pred_pc == f_inc_pc);
  a_r2_uncond_target: assert property (@(posedge clk) disable iff (!rst_n)
    (f_cls == CLS_JMP || f_cls == CLS_CALL) |-> pred_pc == f_imm);
  a_r3_cond_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (f_cls == CLS_JCC) |-> pred_pc == f_imm);
  a_r4_ret_no_guess: assert property (@(posedge clk) disable iff (!rst_n)
    (f_cls == CLS_RET) |-> pred_pc == f_inc_pc);
  a_r5_mispredict: assert property (@(posedge clk) disable iff (!rst_n)
    misp |-> fetch_pc == m_alt_pc);
  a_r6_return_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (retw && !misp) |-> fetch_pc == w_load);
  a_r7_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (retw && misp) |-> fetch_pc == m_alt_pc);
  a_r8_use_guess: assert property (@(posedge clk) disable iff (!rst_n)
    (!retw && !misp) |-> fetch_pc == pred_q);
  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_f |=> pred_q == $past(pred_pc));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall_f |=> $stable(pred_q));
endmodule

bind npc_unit npc_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall_f(stall_f), .f_cls(f_cls),
  .f_inc_pc(f_inc_pc), .f_imm(f_imm), .m_cls(m_cls), .m_taken(m_taken),
  .m_alt_pc(m_alt_pc), .w_cls(w_cls), .w_load(w_load),
  .fetch_pc(fetch_pc), .pred_pc(pred_pc), .pred_q(pred_q)
);

// File: tb/npc_unit_test.sv
module npc_unit_test;
  localparam int PERIOD = 10;
  localparam int AW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall_f = 1'b0;
  logic [3:0]    f_cls = 4'h0;
  logic [AW-1:0] f_inc_pc = '0;
  logic [AW-1:0] f_imm = '0;
  logic [3:0]    m_cls = 4'h0;
  logic          m_taken = 1'b1;
  logic [AW-1:0] m_alt_pc = '0;
  logic [3:0]    w_cls = 4'h0;
  logic [AW-1:0] w_load = '0;
  logic [AW-1:0] fetch_pc;
  logic [AW-1:0] pred_pc;

  int n_cmp = 0;
  int n_bad = 0;
  logic [AW-1:0] model_q = '0;

  always #(PERIOD/2) clk = ~clk;

  npc_unit #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .stall_f(stall_f), .f_cls(f_cls),
    .f_inc_pc(f_inc_pc), .f_imm(f_imm), .m_cls(m_cls), .m_taken(m_taken),
    .m_alt_pc(m_alt_pc), .w_cls(w_cls), .w_load(w_load),
    .fetch_pc(fetch_pc), .pred_pc(pred_pc)
  );

  // behavioural reference: one integer register, updated at the edge
  always @(posedge clk) begin
    if (!rst_n) model_q <= '0;
    else if (!stall_f) model_q <= exp_guess();
  end

  function automatic logic [AW-1:0] exp_guess();
    if (f_cls == 4'h7 || f_cls == 4'h8 || f_cls == 4'h9) return f_imm;
    return f_inc_pc;
  endfunction

  task automatic cmp(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_now();
    string gt, ft;
    logic [AW-1:0] ef;
    if (f_cls == 4'h7) gt = "R3";
    else if (f_cls == 4'h8 || f_cls == 4'h9) gt = "R2";
    else if (f_cls == 4'hA) gt = "R4";
    else gt = "R1";
    cmp({gt, " pred_pc"}, pred_pc, exp_guess());
    if (m_cls == 4'h7 && !m_taken) begin
      ef = m_alt_pc; ft = (w_cls == 4'hA) ? "R7" : "R5";
    end else if (w_cls == 4'hA) begin
      ef = w_load; ft = "R6";
    end else begin
      ef = model_q; ft = stall_f ? "R9" : "R8";
    end
    if (!rst_n) ft = "R10";
    cmp({ft, " fetch_pc"}, fetch_pc, ef);
  endtask

  task automatic step(input logic st, input logic [3:0] fc, input logic [3:0] mc,
                      input logic mt, input logic [3:0] wc);
    @(negedge clk);
    stall_f = st; f_cls = fc; m_cls = mc; m_taken = mt; w_cls = wc;
    f_inc_pc = {$urandom, $urandom}; f_imm = {$urandom, $urandom};
    m_alt_pc = {$urandom, $urandom}; w_load = {$urandom, $urandom};
    #1 check_now();
  endtask

  initial begin
    #(PERIOD*100000);
    n_bad++;
    $display("FAIL watchdog R8 actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R10: reset state seen through fetch_pc
    step(1'b0, 4'h0, 4'h0, 1'b1, 4'h0);
    step(1'b0, 4'h8, 4'h0, 1'b1, 4'h0);
    @(negedge clk); rst_n = 1'b1;
    // R1..R4 guesses, then R8 follow-through
    step(1'b0, 4'h0, 4'h0, 1'b1, 4'h0);
    step(1'b0, 4'h7, 4'h0, 1'b1, 4'h0);
    step(1'b0, 4'h8, 4'h0, 1'b1, 4'h0);
    step(1'b0, 4'h9, 4'h0, 1'b1, 4'h0);
    step(1'b0, 4'hA, 4'h0, 1'b1, 4'h0);
    step(1'b0, 4'h3, 4'h0, 1'b1, 4'h0);
    // R9: stall holds
    step(1'b1, 4'h8, 4'h0, 1'b1, 4'h0);
    step(1'b1, 4'h7, 4'h0, 1'b1, 4'h0);
    step(1'b0, 4'h2, 4'h0, 1'b1, 4'h0);
    // R5: redirect and the no-redirect cases
    step(1'b0, 4'h0, 4'h7, 1'b0, 4'h0);
    step(1'b0, 4'h0, 4'h7, 1'b1, 4'h0);
    step(1'b0, 4'h0, 4'h8, 1'b0, 4'h0);
    // R6 and R7
    step(1'b1, 4'h0, 4'h0, 1'b1, 4'hA);
    step(1'b0, 4'h0, 4'h7, 1'b0, 4'hA);
    step(1'b0, 4'h0, 4'h7, 1'b1, 4'hA);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] fc, mc, wc;
      fc = ($urandom % 2) ? 4'(7 + $urandom % 4) : 4'($urandom);
      mc = ($urandom % 2) ? 4'h7 : 4'($urandom);
      wc = ($urandom % 3 == 0) ? 4'hA : 4'($urandom);
      step(1'($urandom % 4 == 0), fc, mc, 1'($urandom), wc);
    end
    // R10 again: reset mid-run clears the register
    @(negedge clk); rst_n = 1'b0;
    step(1'b0, 4'h0, 4'h0, 1'b1, 4'h0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 4'h0, 4'h0, 1'b1, 4'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule